// File: doc/BRIEF.md
# Serial Bus Message Length Register

This block holds the data-byte count of a message on a multi-master serial bus and counts the bytes down while the message's data field is on the wire. The host writes the length it wants to send into a transmit-length register. The value of that register is driven out as the content of the outgoing length field. The bus receiver hands over the length field of an incoming message with a capture strobe, and host reads return that captured value. A host therefore never reads back what it wrote.

Hardware loads the transmit length with one byte when a control request asks for status or lock information. It does the same when the unit has lost arbitration and the winner then asks it for its status. After that, the host must write its intended length again before it retries. When the data field begins, a 9-bit down-counter loads either the transmit length or the received length. Byte-done strobes from the bit engine step the counter down, and a last-byte flag marks the final byte. A length code of zero stands for 256 bytes.

Top module: `msg_len_unit`

## Requirements
- R1: After reset, txLenField and cpuRdData both read 8'h01 and lastByte is 0.
- R2: A CPU write (cpuWrEn) loads cpuWrData into txLenField at the next clock edge and leaves cpuRdData unchanged.
- R3: A capture strobe (rxLenValid) loads rxLenData into cpuRdData at the next clock edge and leaves txLenField unchanged.
- R4: When ctrlValid is high and ctrlCode (4 bits) is 4'h0, 4'h4, 4'h5 or 4'h6, txLenField becomes 8'h01 at the next edge. All other codes leave it unchanged.
- R5: An arbLost pulse arms a flag. A later slvStatReq while the flag is armed sets txLenField to 8'h01 and clears the flag. A slvStatReq without an armed flag has no effect. dataStart also clears the flag.
- R6: A hardware force to 8'h01 (R4 or R5) wins over a CPU write in the same cycle.
- R7: On dataStart the counter loads the selected length N. lastByte is high exactly after N-1 byteDone strobes, and it falls at the Nth strobe.
- R8: Length code 8'h00 counts as 256 bytes, so lastByte rises only after 255 byteDone strobes.
- R9: With txMode high, dataStart loads the transmit length. With txMode low, it loads the captured receive length. Both values are taken as they stand before that edge.
- R10: byteDone while the counter is idle has no effect, and lastByte stays 0. If dataStart and byteDone arrive together, the load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuWrEn | input | 1 | Host write strobe for the transmit length |
| cpuWrData | input | 8 | Host write data |
| cpuRdData | output | 8 | Host read view: last received length field |
| rxLenValid | input | 1 | Capture strobe for the received length field |
| rxLenData | input | 8 | Received length field |
| ctrlValid | input | 1 | Decoded control code is valid |
| ctrlCode | input | 4 | Decoded control code |
| arbLost | input | 1 | Arbitration was lost |
| slvStatReq | input | 1 | Status request from the winning master |
| dataStart | input | 1 | Data field begins; load the counter |
| txMode | input | 1 | 1 = transmitting, 0 = receiving |
| byteDone | input | 1 | One data byte finished |
| txLenField | output | 8 | Length value sent in the outgoing length field |
| lastByte | output | 1 | Current byte is the last of the data field |

## Verification
The bench goes after these corner cases:
- **Read/write crossover.** A design that crosses the two views would echo host writes on cpuRdData.
- **Zero length code.** A design that treats 8'h00 as zero bytes would raise lastByte at once or never.
- **Force priority.** A design that lets the CPU win over a same-cycle force would send a stale length after a status request.
- **Unarmed status request.** A design that ignores the arbitration-lost condition would clobber the length on every status request.
- **Idle byte strobes.** A counter that underflows would wrap and show lastByte spuriously much later.

Random streams of all strobes are checked against a bench reference model every cycle, alongside directed 1-, 2- and 256-byte data fields.

// File: rtl/msg_len_pkg.sv
package msg_len_pkg;
  parameter int LEN_W = 8;
  parameter int CNT_W = LEN_W + 1;

  typedef struct packed {
    logic loadTx;
    logic forceOne;
    logic captureRx;
    logic loadCnt;
    logic decCnt;
    logic useTx;
  } lenStrb_t;
endpackage

// File: rtl/msg_len_ctrl.sv
module msg_len_ctrl
  import msg_len_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cpuWrEn,
  input  logic     rxLenValid,
  input  logic     ctrlValid,
  input  logic [3:0] ctrlCode,
  input  logic     arbLost,
  input  logic     slvStatReq,
  input  logic     dataStart,
  input  logic     txMode,
  input  logic     byteDone,
  output lenStrb_t strb
);
  logic lostArmed;
  logic codeForce;
  logic arbForce;

  always_comb begin
    unique case (ctrlCode)
      4'h0, 4'h4, 4'h5, 4'h6: codeForce = ctrlValid;
      default:                codeForce = 1'b0;
    endcase
  end

  assign arbForce = slvStatReq & lostArmed;

  always_ff @(posedge clk) begin
    if (!rstN) lostArmed <= 1'b0;
    else if (arbLost) lostArmed <= 1'b1;
    else if (dataStart || arbForce) lostArmed <= 1'b0;
  end

  always_comb begin
    strb.forceOne  = codeForce | arbForce;
    strb.loadTx    = cpuWrEn & ~strb.forceOne;
    strb.captureRx = rxLenValid;
    strb.loadCnt   = dataStart;
    strb.decCnt    = byteDone & ~dataStart;
    strb.useTx     = txMode;
  end

  // R6: a CPU write is never issued together with a force
  a_r6_force_blocks_write: assert property (@(posedge clk) disable iff (!rstN)
    strb.forceOne |-> !strb.loadTx);
  // R5: an unarmed status request with no control force causes no force
  a_r5_unarmed_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (slvStatReq && !lostArmed && !codeForce) |-> !strb.forceOne);
  // R5: consuming the armed flag clears it
  a_r5_flag_consumed: assert property (@(posedge clk) disable iff (!rstN)
    (arbForce && !arbLost) |=> !lostArmed);
endmodule

// File: rtl/msg_len_dp.sv
module msg_len_dp
  import msg_len_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  lenStrb_t         strb,
  input  logic [LEN_W-1:0] wrData,
  input  logic [LEN_W-1:0] rxData,
  output logic [LEN_W-1:0] txLen,
  output logic [LEN_W-1:0] rxLen,
  output logic             lastByte
);
  localparam logic [LEN_W-1:0] ONE_LEN = LEN_W'(1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(1) << LEN_W;

  logic [CNT_W-1:0] remCnt;
  logic [LEN_W-1:0] selLen;
  logic [CNT_W-1:0] loadVal;

  always_ff @(posedge clk) begin
    if (!rstN) txLen <= ONE_LEN;
    else if (strb.forceOne) txLen <= ONE_LEN;
    else if (strb.loadTx) txLen <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rxLen <= ONE_LEN;
    else if (strb.captureRx) rxLen <= rxData;
  end

  assign selLen  = strb.useTx ? txLen : rxLen;
  assign loadVal = (selLen == '0) ? FULL_CNT : {1'b0, selLen};

  always_ff @(posedge clk) begin
    if (!rstN) remCnt <= '0;
    else if (strb.loadCnt) remCnt <= loadVal;
    else if (strb.decCnt && remCnt != '0) remCnt <= remCnt - 1'b1;
  end

  assign lastByte = (remCnt == CNT_W'(1));

  // R6: a force always leaves the one-byte length
  a_r6_force_wins: assert property (@(posedge clk) disable iff (!rstN)
    strb.forceOne |=> txLen == ONE_LEN);
  // R3: captured length appears on the read view
  a_r3_rx_capture: assert property (@(posedge clk) disable iff (!rstN)
    strb.captureRx |=> rxLen == $past(rxData));
  // R8: counter never exceeds 256
  a_r8_cnt_range: assert property (@(posedge clk) disable iff (!rstN)
    remCnt <= FULL_CNT);
  // R10: an idle counter stays idle without a load
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (remCnt == '0 && !strb.loadCnt) |=> remCnt == '0);
  // R7: a byte strobe on the last byte ends the field
  a_r7_last_ends: assert property (@(posedge clk) disable iff (!rstN)
    (lastByte && strb.decCnt) |=> !lastByte);
endmodule

// File: rtl/msg_len_unit.sv
module msg_len_unit
  import msg_len_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuWrEn,
  input  logic [7:0] cpuWrData,
  output logic [7:0] cpuRdData,
  input  logic       rxLenValid,
  input  logic [7:0] rxLenData,
  input  logic       ctrlValid,
  input  logic [3:0] ctrlCode,
  input  logic       arbLost,
  input  logic       slvStatReq,
  input  logic       dataStart,
  input  logic       txMode,
  input  logic       byteDone,
  output logic [7:0] txLenField,
  output logic       lastByte
);
  lenStrb_t strb;

  msg_len_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cpuWrEn(cpuWrEn), .rxLenValid(rxLenValid),
    .ctrlValid(ctrlValid), .ctrlCode(ctrlCode), .arbLost(arbLost),
    .slvStatReq(slvStatReq), .dataStart(dataStart), .txMode(txMode),
    .byteDone(byteDone), .strb(strb)
  );

  msg_len_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(cpuWrData),
    .rxData(rxLenData), .txLen(txLenField), .rxLen(cpuRdData),
    .lastByte(lastByte)
  );
endmodule

// File: tb/msg_len_unit_test.sv
module msg_len_unit_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuWrEn = 0, rxLenValid = 0, ctrlValid = 0, arbLost = 0;
  logic slvStatReq = 0, dataStart = 0, txMode = 0, byteDone = 0;
  logic [7:0] cpuWrData = 0, rxLenData = 0;
  logic [3:0] ctrlCode = 0;
  logic [7:0] cpuRdData, txLenField;
  logic lastByte;

  int nVec = 0;
  int nBad = 0;
  logic [7:0] mTx, mRx;
  logic mArmed;
  int mCnt;

  always #4 clk = ~clk;

  msg_len_unit uut (.*);

  function automatic bit isForceCode(logic v, logic [3:0] c);
    return v && (c == 4'h0 || c == 4'h4 || c == 4'h5 || c == 4'h6);
  endfunction

  function automatic int lenToCount(logic [7:0] l);
    return (l == 8'h00) ? 256 : int'(l);
  endfunction

  task automatic modelReset();
    mTx = 8'h01; mRx = 8'h01; mArmed = 0; mCnt = 0;
  endtask

  task automatic modelStep();
    bit force1;
    int nCnt;
    force1 = isForceCode(ctrlValid, ctrlCode) || (slvStatReq && mArmed);
    if (dataStart) nCnt = lenToCount(txMode ? mTx : mRx);
    else if (byteDone && mCnt > 0) nCnt = mCnt - 1;
    else nCnt = mCnt;
    if (arbLost) mArmed = 1;
    else if (dataStart || (slvStatReq && mArmed)) mArmed = 0;
    if (force1) mTx = 8'h01;
    else if (cpuWrEn) mTx = cpuWrData;
    if (rxLenValid) mRx = rxLenData;
    mCnt = nCnt;
  endtask

  task automatic check(string req);
    nVec++;
    if (txLenField !== mTx || cpuRdData !== mRx || lastByte !== (mCnt == 1)) begin
      nBad++;
      $display("FAIL %s: tx=%h rd=%h last=%b expected tx=%h rd=%h last=%b",
               req, txLenField, cpuRdData, lastByte, mTx, mRx, mCnt == 1);
    end
  endtask

  task automatic clearIn();
    cpuWrEn = 0; rxLenValid = 0; ctrlValid = 0; arbLost = 0;
    slvStatReq = 0; dataStart = 0; byteDone = 0;
  endtask

  task automatic cyc(string req);
    @(posedge clk);
    modelStep();
    #1;
    check(req);
    @(negedge clk);
    clearIn();
  endtask

  initial begin : watchdog
    #1600000;
    nBad++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'd5151));
    modelReset();
    repeat (3) @(negedge clk);
    nVec++;
    if (txLenField !== 8'h01 || cpuRdData !== 8'h01 || lastByte !== 1'b0) begin
      nBad++;
      $display("FAIL R1: tx=%h rd=%h last=%b expected 01 01 0", txLenField, cpuRdData, lastByte);
    end
    rstN = 1;

    // R2: write is not visible on read view
    cpuWrEn = 1; cpuWrData = 8'h5A; cyc("R2");
    // R3: capture is not visible on tx field
    rxLenValid = 1; rxLenData = 8'h03; cyc("R3");
    // R4: forcing and non-forcing codes
    ctrlValid = 1; ctrlCode = 4'h3; cyc("R4");
    ctrlValid = 1; ctrlCode = 4'h5; cyc("R4");
    cpuWrEn = 1; cpuWrData = 8'h22; cyc("R2");
    // R6: force against same-cycle write
    ctrlValid = 1; ctrlCode = 4'h0; cpuWrEn = 1; cpuWrData = 8'h77; cyc("R6");
    cpuWrEn = 1; cpuWrData = 8'h40; cyc("R2");
    // R5: unarmed request ignored, then armed
    slvStatReq = 1; cyc("R5");
    arbLost = 1; cyc("R5");
    slvStatReq = 1; cpuWrEn = 1; cpuWrData = 8'h09; cyc("R6");
    cpuWrEn = 1; cpuWrData = 8'h02; cyc("R5");
    slvStatReq = 1; cyc("R5");
    // R9 + R7: two-byte tx field
    dataStart = 1; txMode = 1; cyc("R9");
    byteDone = 1; cyc("R7");
    byteDone = 1; cyc("R7");
    // R10: idle byte strobes
    byteDone = 1; cyc("R10");
    // R9: rx length (3) selected
    dataStart = 1; txMode = 0; cyc("R9");
    repeat (3) begin byteDone = 1; cyc("R7"); end
    // R8: 256-byte field
    cpuWrEn = 1; cpuWrData = 8'h00; cyc("R8");
    dataStart = 1; txMode = 1; byteDone = 1; cyc("R10");
    for (int i = 0; i < 256; i++) begin byteDone = 1; cyc("R8"); end

    // random mix
    for (int i = 0; i < 4000; i++) begin
      cpuWrEn    = ($urandom_range(0, 3) == 0);
      cpuWrData  = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'($urandom_range(0, 4));
      rxLenValid = ($urandom_range(0, 4) == 0);
      rxLenData  = 8'($urandom_range(0, 5));
      ctrlValid  = ($urandom_range(0, 5) == 0);
      ctrlCode   = 4'($urandom);
      arbLost    = ($urandom_range(0, 9) == 0);
      slvStatReq = ($urandom_range(0, 6) == 0);
      dataStart  = ($urandom_range(0, 7) == 0);
      txMode     = 1'($urandom);
      byteDone   = ($urandom_range(0, 1) == 0);
      cyc("R7 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule